// File: doc/BRIEF.md
# Error-State Snapshot Register Bank

This block keeps a copy of processor state taken when a machine-check error is detected. When the error-detect strobe is high on a clock edge, the bank loads the general-purpose register values, the flags word and the instruction pointer into its snapshot entries. In the same edge it also loads the status word and the faulting address of one error-reporting bank. Handler software then reads the entries through a plain register port to find out what the core was doing when the error occurred.

The entries follow a read/write-to-zero rule. Reads return the stored value. A write of all zeros clears the addressed entry. A write of any other value leaves the entry as it was and raises a fault pulse, which the surrounding logic turns into a protection exception. Hard reset clears every entry. Soft reset keeps the contents, so a handler that runs after a soft restart can still inspect the snapshot. Two legacy addresses kept for older handlers are not separate storage: they read and write the error bank's status and address entries.

Top module: `snap_bank`

## Requirements
- R1: When `cap_strobe` is high on a rising edge, every entry loads its capture input on that edge. The entries are GPR slot i from `cap_gpr[i*64 +: 64]`, then flags, instruction pointer, bank status and bank address. The new values are readable in the following cycle.
- R2: Address map (12-bit). GPR slot i is at 0x188+i for i = 0..15, which puts slot 14 at 0x196 and slot 15 at 0x197. Flags are at 0x198, the instruction pointer at 0x199, bank status at 0x401 and bank address at 0x402. `acc_rdata` is combinational from `acc_addr`.
- R3: A write (`acc_wr` = 1) of all zeros to a mapped address clears that entry at the clock edge and raises no fault.
- R4: A write of a non-zero value to a mapped address leaves the entry unchanged and drives `acc_fault` high in the next cycle.
- R5: Hard reset (`rst`, synchronous, active high) clears every entry and `acc_fault`.
- R6: Soft reset (`soft_rst`) leaves every entry unchanged. Its only effect is to clear `acc_fault` on the next cycle, including any fault raised by a write in that same cycle.
- R7: Legacy address 0x000 reads and writes the bank status entry, and legacy address 0x001 reads and writes the bank address entry. The same read/write-to-zero rule applies.
- R8: A read of an unmapped address returns zero. A write to an unmapped address changes nothing and raises no fault.
- R9: `acc_fault` is high for exactly one cycle per faulting write.
- R10: If a capture and a software write occur in the same cycle, the capture wins for every entry and the write is dropped. A non-zero write in that cycle still faults.
- R11: Each capture overwrites the previous snapshot completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset; entries keep their contents |
| cap_strobe | input | 1 | Error-detect strobe; loads the snapshot |
| cap_gpr | input | 1024 | Sixteen 64-bit GPR values, slot i at bits i*64 upward |
| cap_flags | input | 64 | Flags word to capture |
| cap_ip | input | 64 | Instruction pointer to capture |
| cap_status | input | 64 | Error-bank status word to capture |
| cap_addr | input | 64 | Error-bank address to capture |
| acc_addr | input | 12 | Register port address |
| acc_wr | input | 1 | Register port write enable |
| acc_wdata | input | 64 | Register port write data |
| acc_rdata | output | 64 | Read data for `acc_addr` |
| acc_fault | output | 1 | One-cycle fault pulse after a non-zero write |

## Verification
The bench checks the edges of the address map: 0x187 and 0x19A, which sit just outside the GPR/flags/IP window, must read zero. A decoder that is off by one would expose a neighbour there or hide slot 15. It makes zero and non-zero writes through both legacy aliases and reads back through the main addresses, so an alias given its own storage would show stale data. It collides captures with writes, both zero and non-zero: a design that let the write win would lose a captured value, and one that dropped the fault would hide the violation. It asserts soft reset around live data and around a faulting write, and any entry cleared by soft reset shows up as a mismatch.

// File: rtl/snap_pkg.sv
package snap_pkg;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Result of address decode: whether the address maps, and which entry.
    typedef struct packed {
        logic hit;
        idx_t idx;
    } sel_t;

    // What a register-port write does to the bank.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_REJECT = 2'd2
    } wr_op_e;

    function automatic wr_op_e classify_write(input logic wr, input logic hit, input word_t wd);
        if (!wr || !hit)
            return OP_IDLE;
        else if (wd == '0)
            return OP_CLEAR;
        else
            return OP_REJECT;
    endfunction

endpackage

// File: rtl/snap_decode.sv
module snap_decode
    import snap_pkg::*;
#(
    parameter int    NUM_GPR   = 16,
    parameter addr_t GPR_BASE  = 12'h188,
    parameter addr_t STAT_ADDR = 12'h401,
    parameter addr_t BADR_ADDR = 12'h402,
    parameter addr_t LEG_STAT  = 12'h000,
    parameter addr_t LEG_BADR  = 12'h001
) (
    input  addr_t addr,
    output sel_t  sel
);
    localparam addr_t GPR_END = addr_t'(GPR_BASE + NUM_GPR);
    localparam addr_t FLG_A   = GPR_END;
    localparam addr_t IP_A    = addr_t'(GPR_BASE + NUM_GPR + 1);

    always_comb begin
        sel = '0;
        if (addr >= GPR_BASE && addr < GPR_END) begin
            sel.hit = 1'b1;
            sel.idx = IDX_W'(addr - GPR_BASE);
        end else if (addr == FLG_A) begin
            sel.hit = 1'b1;
            sel.idx = IDX_W'(NUM_GPR);
        end else if (addr == IP_A) begin
            sel.hit = 1'b1;
            sel.idx = IDX_W'(NUM_GPR + 1);
        end else if (addr == STAT_ADDR || addr == LEG_STAT) begin
            sel.hit = 1'b1;
            sel.idx = IDX_W'(NUM_GPR + 2);
        end else if (addr == BADR_ADDR || addr == LEG_BADR) begin
            sel.hit = 1'b1;
            sel.idx = IDX_W'(NUM_GPR + 3);
        end
    end
endmodule

// File: rtl/snap_store.sv
module snap_store
    import snap_pkg::*;
#(
    parameter int NUM_ENT = 20
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_en,
    input  word_t  cap_val [NUM_ENT],
    input  wr_op_e op,
    input  idx_t   idx,
    output word_t  ent [NUM_ENT]
);
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        word_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (cap_en)
                q <= cap_val[e];
            else if (op == OP_CLEAR && idx == IDX_W'(e))
                q <= '0;
        end
        assign ent[e] = q;
    end
endmodule

// File: rtl/snap_fault.sv
module snap_fault
    import snap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   soft_rst,
    input  wr_op_e op,
    output logic   fault
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            fault <= 1'b0;
        else
            fault <= (op == OP_REJECT);
    end
endmodule

// File: rtl/snap_bank.sv
module snap_bank
    import snap_pkg::*;
#(
    parameter int    NUM_GPR   = 16,
    parameter addr_t GPR_BASE  = 12'h188,
    parameter addr_t STAT_ADDR = 12'h401,
    parameter addr_t BADR_ADDR = 12'h402,
    parameter addr_t LEG_STAT  = 12'h000,
    parameter addr_t LEG_BADR  = 12'h001
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      soft_rst,
    input  logic                      cap_strobe,
    input  logic [NUM_GPR*DATA_W-1:0] cap_gpr,
    input  logic [DATA_W-1:0]         cap_flags,
    input  logic [DATA_W-1:0]         cap_ip,
    input  logic [DATA_W-1:0]         cap_status,
    input  logic [DATA_W-1:0]         cap_addr,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic                      acc_wr,
    input  logic [DATA_W-1:0]         acc_wdata,
    output logic [DATA_W-1:0]         acc_rdata,
    output logic                      acc_fault
);
    localparam int NUM_ENT = NUM_GPR + 4;
    localparam int E_FLG   = NUM_GPR;
    localparam int E_IP    = NUM_GPR + 1;
    localparam int E_STAT  = NUM_GPR + 2;
    localparam int E_BADR  = NUM_GPR + 3;

    sel_t   sel;
    wr_op_e op;
    logic   dec_hit;
    word_t  cap_val [NUM_ENT];
    word_t  ent     [NUM_ENT];

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
        assign cap_val[g] = cap_gpr[g*DATA_W +: DATA_W];
    end
    assign cap_val[E_FLG]  = cap_flags;
    assign cap_val[E_IP]   = cap_ip;
    assign cap_val[E_STAT] = cap_status;
    assign cap_val[E_BADR] = cap_addr;

    snap_decode #(
        .NUM_GPR  (NUM_GPR),
        .GPR_BASE (GPR_BASE),
        .STAT_ADDR(STAT_ADDR),
        .BADR_ADDR(BADR_ADDR),
        .LEG_STAT (LEG_STAT),
        .LEG_BADR (LEG_BADR)
    ) i_decode (
        .addr(acc_addr),
        .sel (sel)
    );

    assign dec_hit = sel.hit;
    assign op      = classify_write(acc_wr, sel.hit, acc_wdata);

    snap_store #(
        .NUM_ENT(NUM_ENT)
    ) i_store (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_strobe),
        .cap_val(cap_val),
        .op     (op),
        .idx    (sel.idx),
        .ent    (ent)
    );

    snap_fault i_fault (
        .clk     (clk),
        .rst     (rst),
        .soft_rst(soft_rst),
        .op      (op),
        .fault   (acc_fault)
    );

    always_comb begin
        acc_rdata = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (sel.hit && sel.idx == IDX_W'(e))
                acc_rdata = ent[e];
        end
    end
endmodule

// File: rtl/snap_bank_chk.sv
module snap_bank_chk
    import snap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              cap_strobe,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              acc_fault,
    input logic              dec_hit
);
    assert_zero_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && dec_hit && acc_wdata == '0 && !cap_strobe)
        |=> (acc_addr != $past(acc_addr)) || (acc_rdata == '0));

    assert_reject_faults_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && dec_hit && acc_wdata != '0 && !soft_rst) |=> acc_fault);

    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_wdata != '0 && !cap_strobe)
        |=> (acc_addr != $past(acc_addr)) || $stable(acc_rdata));

    assert_hard_reset_R5: assert property (@(posedge clk)
        rst |=> (acc_rdata == '0 && !acc_fault));

    assert_soft_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !cap_strobe && !acc_wr)
        |=> (acc_addr != $past(acc_addr)) || $stable(acc_rdata));

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_fault && !(acc_wr && dec_hit && acc_wdata != '0)) |=> !acc_fault);
endmodule

bind snap_bank snap_bank_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .cap_strobe(cap_strobe),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .acc_fault (acc_fault),
    .dec_hit   (dec_hit)
);

// File: tb/test_snap_bank.sv
`timescale 1ns/1ps
module test_snap_bank;
    import snap_pkg::*;

    localparam int NG = 16;
    localparam int NE = NG + 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 soft_rst = 1'b0;
    logic                 cap_strobe = 1'b0;
    logic [NG*DATA_W-1:0] cap_gpr = '0;
    logic [DATA_W-1:0]    cap_flags = '0, cap_ip = '0, cap_status = '0, cap_addr = '0;
    logic [ADDR_W-1:0]    acc_addr = '0;
    logic                 acc_wr = 1'b0;
    logic [DATA_W-1:0]    acc_wdata = '0;
    logic [DATA_W-1:0]    acc_rdata;
    logic                 acc_fault;

    logic [DATA_W-1:0] mdl [NE];
    logic              mdl_fault = 1'b0;
    int n_chk = 0;
    int n_bad = 0;

    snap_bank i_snap_bank (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .cap_strobe(cap_strobe),
        .cap_gpr(cap_gpr), .cap_flags(cap_flags), .cap_ip(cap_ip),
        .cap_status(cap_status), .cap_addr(cap_addr),
        .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_fault(acc_fault)
    );

    // Entry index per the address map of R2 and R7; -1 when unmapped (R8).
    function automatic int ref_idx(input logic [ADDR_W-1:0] a);
        int v = int'(a);
        if (v >= 'h188 && v <= 'h197) return v - 'h188;
        if (v == 'h198) return NG;
        if (v == 'h199) return NG + 1;
        if (v == 'h401 || v == 'h000) return NG + 2;
        if (v == 'h402 || v == 'h001) return NG + 3;
        return -1;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, acc_addr, act, exp);
        end
    endtask

    // One clock: update the reference at the edge, compare at the falling edge.
    task automatic step(input string tag);
        int k;
        @(posedge clk);
        k = ref_idx(acc_addr);
        mdl_fault = !rst && !soft_rst && acc_wr && k >= 0 && acc_wdata != '0;
        if (rst) begin
            for (int i = 0; i < NE; i++) mdl[i] = '0;
        end else if (cap_strobe) begin
            for (int i = 0; i < NG; i++) mdl[i] = cap_gpr[i*DATA_W +: DATA_W];
            mdl[NG]     = cap_flags;
            mdl[NG + 1] = cap_ip;
            mdl[NG + 2] = cap_status;
            mdl[NG + 3] = cap_addr;
        end else if (acc_wr && k >= 0 && acc_wdata == '0) begin
            mdl[k] = '0;
        end
        @(negedge clk);
        k = ref_idx(acc_addr);
        check(tag, "rdata", acc_rdata, (k >= 0) ? mdl[k] : '0);
        check(tag, "fault", {63'd0, acc_fault}, {63'd0, mdl_fault});
    endtask

    task automatic load_pattern(input logic [31:0] seed);
        for (int i = 0; i < NG; i++)
            cap_gpr[i*DATA_W +: DATA_W] = {seed, 32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000};
        cap_flags  = {seed, 32'h0000_F1A6};
        cap_ip     = {seed, 32'h1234_5678};
        cap_status = {seed ^ 32'h8000_0000, 32'h0000_0C0D};
        cap_addr   = {~seed, 32'hDEAD_BEEF};
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        acc_addr = a; acc_wr = 1'b1; acc_wdata = d;
        step(tag);
        acc_wr = 1'b0; acc_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        acc_addr = a;
        step(tag);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) mdl[i] = '0;
        // R5: reset state
        rst = 1'b1;
        step("R5"); step("R5");
        rst = 1'b0;
        rd(12'h196, "R5");

        // R1: capture, then R2: walk the map
        load_pattern(32'h1111_0000);
        cap_strobe = 1'b1; step("R1"); cap_strobe = 1'b0;
        for (int a = 'h188; a <= 'h199; a++) rd(ADDR_W'(a), "R2");
        rd(12'h401, "R2"); rd(12'h402, "R2");
        // R7: legacy aliases read the bank entries
        rd(12'h000, "R7"); rd(12'h001, "R7");

        // R3: zero write clears, neighbour untouched
        wr(12'h196, '0, "R3");
        rd(12'h196, "R3"); rd(12'h197, "R3");

        // R4 / R9: non-zero write rejected, single-cycle fault
        wr(12'h197, 64'h5, "R4");
        rd(12'h197, "R9");
        wr(12'h198, 64'h1, "R9"); wr(12'h198, 64'h2, "R9");
        rd(12'h198, "R9"); rd(12'h198, "R9");

        // R7: writes through legacy addresses reach the bank entries
        wr(12'h001, '0, "R7");
        rd(12'h402, "R7");
        wr(12'h000, 64'hFF, "R7");
        rd(12'h401, "R7");

        // R8: unmapped reads and writes
        rd(12'h300, "R8");
        wr(12'h300, 64'hFFFF, "R8");
        rd(12'hFFF, "R8"); rd(12'h187, "R8"); rd(12'h19A, "R8"); rd(12'h403, "R8");

        // R6: soft reset keeps contents, suppresses fault
        acc_addr = 12'h188; soft_rst = 1'b1; step("R6"); step("R6");
        acc_wr = 1'b1; acc_wdata = 64'h3; step("R6");
        acc_wr = 1'b0; acc_wdata = '0; soft_rst = 1'b0;
        rd(12'h199, "R6"); rd(12'h188, "R6");

        // R10: capture beats a same-cycle write
        load_pattern(32'h2222_0000);
        cap_strobe = 1'b1; acc_addr = 12'h189; acc_wr = 1'b1; acc_wdata = '0;
        step("R10");
        cap_strobe = 1'b0; acc_wr = 1'b0;
        rd(12'h189, "R10");
        load_pattern(32'h2323_0000);
        cap_strobe = 1'b1; acc_addr = 12'h18A; acc_wr = 1'b1; acc_wdata = 64'h7;
        step("R10");
        cap_strobe = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
        rd(12'h18A, "R10");

        // R11: a later capture overwrites the whole snapshot
        wr(12'h196, '0, "R11");
        load_pattern(32'h3333_0000);
        cap_strobe = 1'b1; step("R11"); cap_strobe = 1'b0;
        rd(12'h196, "R11"); rd(12'h199, "R11"); rd(12'h402, "R11");

        // R5: hard reset mid-run clears everything
        rst = 1'b1; step("R5"); rst = 1'b0;
        for (int a = 'h188; a <= 'h199; a++) rd(ADDR_W'(a), "R5");
        rd(12'h401, "R5"); rd(12'h001, "R5");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule